// File: doc/BRIEF.md
# Alternating Twin-Bank Frame Buffer Sequencer

This block sequences two external single-port SRAM banks for a three-pass separable image transform. In every pass one bank is the source and the other the destination. The block reads the source bank and streams words out to the processing datapath. It accepts the processed words back and writes them into the destination bank. When a pass completes, the two banks exchange roles, so the result of one pass becomes the input of the next pass.

The block is clocked at the memory rate. An internal processing clock enable runs at half that rate. Each memory word packs two adjacent samples. Source reads are issued on the half cycles when the enable is low. The returned word is offered on the half cycle when the enable is high.

Passes run in a fixed cycle of three. The first pass scans the image in row order and the second in column order, so that pass sees the image transposed. The third pass scans in row order again. A `start_i` pulse launches each pass, and `pass_done_o` marks the single cycle in which the bank roles are exchanged.

Top module: `pp_buffer_ctrl`

## Requirements
- R1: After reset, these outputs are low: `rd_valid_o`, `wr_ready_o`, `pass_done_o`, `m0_en_o` and `m1_en_o`. `pass_idx_o` is 0, and `rd_bank_o` is 0, which means bank 0 is the source.
- R2: `proc_ce_o` inverts on every clock cycle after reset. `rd_valid_o` and `wr_ready_o` are high only in cycles where `proc_ce_o` is high.
- R3: Reads go only to the bank selected by `rd_bank_o`, and only with write enable low. Writes go only to the other bank, and only with write enable high. A write happens exactly when `wr_valid_i` and `wr_ready_o` are both high in the same cycle.
- R4: In passes 0 and 2, both the read addresses and the write addresses run row by row. The word index k maps to address k, where address = row*PAIRS + pair and the pair index advances fastest.
- R5: In pass 1 (`col_scan_o` high), both the read addresses and the write addresses take the row index fastest. The word index k maps to address (k mod ROWS)*PAIRS + (k div ROWS).
- R6: Bits [SAMPLE_W-1:0] of a word hold the even-column sample and the upper half holds the odd-column sample. Words pass through unchanged: the k-th word delivered equals the source word at the k-th scan address.
- R7: Read back-pressure: if `rd_valid_o` is high while `rd_ready_i` is low, the same word is offered again two cycles later. No word is lost or repeated, and each pass delivers exactly ROWS*PAIRS words.
- R8: `pass_done_o` is a one-cycle pulse in the cycle right after the later of the final read handshake and the final write handshake. In that cycle neither bank is enabled. In the next cycle `rd_bank_o` has inverted and `pass_idx_o` has advanced in the order 0, 1, 2, 0.
- R9: A `start_i` pulse while a pass is running has no effect. The pass keeps its address sequence and word count, and it ends with exactly one `pass_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a pass when idle |
| pass_done_o | output | 1 | Swap cycle at the end of a pass |
| pass_idx_o | output | 2 | Current pass number, 0 to 2 |
| col_scan_o | output | 1 | High when the current pass scans in column order |
| rd_bank_o | output | 1 | Index of the source bank |
| proc_ce_o | output | 1 | Half-rate processing clock enable |
| rd_valid_o | output | 1 | Source word offered |
| rd_ready_i | input | 1 | Datapath accepts the source word |
| rd_data_o | output | 2*SAMPLE_W | Source word holding two samples |
| wr_valid_i | input | 1 | Result word offered by the datapath |
| wr_ready_o | output | 1 | Block accepts a result word |
| wr_data_i | input | 2*SAMPLE_W | Result word holding two samples |
| m0_en_o | output | 1 | Bank 0 access enable |
| m0_we_o | output | 1 | Bank 0 write enable |
| m0_addr_o | output | ADDR_W | Bank 0 word address |
| m0_wdata_o | output | 2*SAMPLE_W | Bank 0 write data |
| m0_rdata_i | input | 2*SAMPLE_W | Bank 0 read data, one cycle after a read |
| m1_en_o | output | 1 | Bank 1 access enable |
| m1_we_o | output | 1 | Bank 1 write enable |
| m1_addr_o | output | ADDR_W | Bank 1 word address |
| m1_wdata_o | output | 2*SAMPLE_W | Bank 1 write data |
| m1_rdata_i | input | 2*SAMPLE_W | Bank 1 read data, one cycle after a read |

## Verification
The bench builds the block with ROWS=4 and PAIRS=3. These are unequal dimensions, so a transposed scan yields addresses that differ from a row scan at almost every step. A full three-pass rotation through both banks fits in a few hundred cycles. At this size every wrap of the row and pair counters happens several times per pass. The bench checks every address and every word of every pass. The third pass runs with read stalls and write gaps of co-prime periods, so stalls land on both phases of the clock enable.

// File: rtl/pp_buf_pkg.sv
`timescale 1ns/1ps
package pp_buf_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_e;

  localparam int unsigned NUM_BANKS  = 2;
  localparam int unsigned NUM_PASSES = 3;

  // Column-order scan applies to the middle pass of the three.
  function automatic logic pass_is_column(input logic [1:0] idx);
    return idx == 2'd1;
  endfunction

  function automatic logic [1:0] next_pass(input logic [1:0] idx);
    return (idx == 2'(NUM_PASSES - 1)) ? 2'd0 : idx + 2'd1;
  endfunction
endpackage

// File: rtl/pp_scan_gen.sv
`timescale 1ns/1ps
module pp_scan_gen #(
  parameter int unsigned ROWS  = 362,
  parameter int unsigned PAIRS = 181,
  localparam int unsigned DEPTH  = ROWS * PAIRS,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned RW     = $clog2(ROWS + 1),
  localparam int unsigned CW     = $clog2(PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              col_mode,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [RW-1:0]     row_q;
  logic [CW-1:0]     pair_q;
  logic [ADDR_W-1:0] base_q;   // row_q * PAIRS, kept incrementally

  logic row_end, pair_end;
  assign row_end  = (row_q == RW'(ROWS - 1));
  assign pair_end = (pair_q == CW'(PAIRS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      pair_q <= '0;
      base_q <= '0;
    end else if (clear) begin
      row_q  <= '0;
      pair_q <= '0;
      base_q <= '0;
    end else if (step) begin
      if (col_mode) begin
        if (row_end) begin
          row_q  <= '0;
          base_q <= '0;
          pair_q <= pair_q + 1'b1;
        end else begin
          row_q  <= row_q + 1'b1;
          base_q <= base_q + ADDR_W'(PAIRS);
        end
      end else begin
        if (pair_end) begin
          pair_q <= '0;
          row_q  <= row_q + 1'b1;
          base_q <= base_q + ADDR_W'(PAIRS);
        end else begin
          pair_q <= pair_q + 1'b1;
        end
      end
    end
  end

  assign addr = base_q + ADDR_W'(pair_q);
  assign last = row_end & pair_end;
endmodule

// File: rtl/pp_read_port.sv
`timescale 1ns/1ps
module pp_read_port #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ce,
  input  logic              can_issue,
  input  logic [WORD_W-1:0] mem_word,
  input  logic              rd_ready,
  output logic              issue,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);
  logic              inflight_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] hold_q;

  // Fetch on the low enable phase so data lands on the high phase.
  assign issue    = can_issue & ~ce & ~hold_full_q & ~inflight_q;
  assign rd_valid = ce & (inflight_q | hold_full_q);
  assign rd_data  = hold_full_q ? hold_q : mem_word;
  assign busy     = inflight_q | hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q  <= 1'b0;
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (clear) begin
      inflight_q  <= 1'b0;
      hold_full_q <= 1'b0;
    end else begin
      inflight_q <= issue;
      if (rd_valid && rd_ready) begin
        hold_full_q <= 1'b0;
      end else if (rd_valid && inflight_q) begin
        hold_q      <= mem_word;
        hold_full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_bank_route.sv
`timescale 1ns/1ps
module pp_bank_route
  import pp_buf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic                              rd_bank,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rdata,
  output logic [NUM_BANKS-1:0]              bank_en,
  output logic [NUM_BANKS-1:0]              bank_we,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]  bank_addr,
  output logic [WORD_W-1:0]                 rd_word
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic is_src;
    assign is_src       = (rd_bank == 1'(b));
    assign bank_en[b]   = is_src ? rd_en : wr_en;
    assign bank_we[b]   = ~is_src & wr_en;
    assign bank_addr[b] = is_src ? rd_addr : wr_addr;
  end

  assign rd_word = bank_rdata[rd_bank];
endmodule

// File: rtl/pp_buffer_ctrl.sv
`timescale 1ns/1ps
module pp_buffer_ctrl
  import pp_buf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ROWS     = 362,
  parameter int unsigned PAIRS    = 181,
  localparam int unsigned WORD_W  = 2 * SAMPLE_W,
  localparam int unsigned DEPTH   = ROWS * PAIRS,
  localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              pass_done_o,
  output logic [1:0]        pass_idx_o,
  output logic              col_scan_o,
  output logic              rd_bank_o,
  output logic              proc_ce_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              m0_en_o,
  output logic              m0_we_o,
  output logic [ADDR_W-1:0] m0_addr_o,
  output logic [WORD_W-1:0] m0_wdata_o,
  input  logic [WORD_W-1:0] m0_rdata_i,
  output logic              m1_en_o,
  output logic              m1_we_o,
  output logic [ADDR_W-1:0] m1_addr_o,
  output logic [WORD_W-1:0] m1_wdata_o,
  input  logic [WORD_W-1:0] m1_rdata_i
);
  ctrl_state_e state_q;
  logic        ce_q;
  logic        rd_bank_q;
  logic [1:0]  pass_q;
  logic        rd_fin_q, wr_fin_q;

  logic running, start_go, col_scan, all_done;
  logic rd_issue, rd_busy, rd_last, wr_last, wr_fire;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_word;

  logic [NUM_BANKS-1:0]             bank_en, bank_we;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_addr;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rdata;

  assign running  = (state_q == ST_RUN);
  assign start_go = (state_q == ST_IDLE) & start_i;
  assign col_scan = pass_is_column(pass_q);
  assign wr_ready_o = running & ce_q & ~wr_fin_q;
  assign wr_fire    = wr_ready_o & wr_valid_i;
  assign all_done   = running & rd_fin_q & wr_fin_q & ~rd_busy;

  pp_scan_gen #(.ROWS(ROWS), .PAIRS(PAIRS)) u_rd_scan (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .step(rd_issue),
    .col_mode(col_scan), .addr(rd_addr), .last(rd_last)
  );

  pp_scan_gen #(.ROWS(ROWS), .PAIRS(PAIRS)) u_wr_scan (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .step(wr_fire),
    .col_mode(col_scan), .addr(wr_addr), .last(wr_last)
  );

  pp_read_port #(.WORD_W(WORD_W)) u_rd_port (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .ce(ce_q),
    .can_issue(running & ~rd_fin_q), .mem_word(rd_word),
    .rd_ready(rd_ready_i), .issue(rd_issue), .rd_valid(rd_valid_o),
    .rd_data(rd_data_o), .busy(rd_busy)
  );

  assign bank_rdata[0] = m0_rdata_i;
  assign bank_rdata[1] = m1_rdata_i;

  pp_bank_route #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_route (
    .rd_bank(rd_bank_q), .rd_en(rd_issue), .rd_addr(rd_addr),
    .wr_en(wr_fire), .wr_addr(wr_addr), .bank_rdata(bank_rdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ce_q      <= 1'b0;
      rd_bank_q <= 1'b0;
      pass_q    <= 2'd0;
      rd_fin_q  <= 1'b0;
      wr_fin_q  <= 1'b0;
    end else begin
      ce_q <= ~ce_q;
      if (start_go) begin
        state_q  <= ST_RUN;
        rd_fin_q <= 1'b0;
        wr_fin_q <= 1'b0;
      end else if (all_done) begin
        state_q   <= ST_IDLE;
        rd_bank_q <= ~rd_bank_q;
        pass_q    <= next_pass(pass_q);
      end else begin
        if (rd_issue && rd_last) rd_fin_q <= 1'b1;
        if (wr_fire && wr_last)  wr_fin_q <= 1'b1;
      end
    end
  end

  assign pass_done_o = all_done;
  assign pass_idx_o  = pass_q;
  assign col_scan_o  = col_scan;
  assign rd_bank_o   = rd_bank_q;
  assign proc_ce_o   = ce_q;

  assign m0_en_o    = bank_en[0];
  assign m0_we_o    = bank_we[0];
  assign m0_addr_o  = bank_addr[0];
  assign m0_wdata_o = wr_data_i;
  assign m1_en_o    = bank_en[1];
  assign m1_we_o    = bank_we[1];
  assign m1_addr_o  = bank_addr[1];
  assign m1_wdata_o = wr_data_i;
endmodule

// File: rtl/pp_buffer_ctrl_chk.sv
`timescale 1ns/1ps
module pp_buffer_ctrl_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pass_done_o,
  input logic              rd_bank_o,
  input logic              proc_ce_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              wr_ready_o,
  input logic              m0_en_o,
  input logic              m0_we_o,
  input logic              m1_en_o,
  input logic              m1_we_o
);
  assert_ce_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (proc_ce_o != $past(proc_ce_o)));

  assert_rd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> proc_ce_o);

  assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> proc_ce_o);

  assert_src_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bank_o ? !m1_we_o : !m0_we_o));

  assert_dst_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bank_o ? !(m0_en_o && !m0_we_o) : !(m1_en_o && !m1_we_o)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |-> ##2 (rd_valid_o && rd_data_o == $past(rd_data_o, 2)));

  assert_swap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |-> (!m0_en_o && !m1_en_o));

  assert_swap_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |=> (rd_bank_o != $past(rd_bank_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |=> !pass_done_o);
endmodule

bind pp_buffer_ctrl pp_buffer_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pass_done_o(pass_done_o), .rd_bank_o(rd_bank_o),
  .proc_ce_o(proc_ce_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o), .wr_ready_o(wr_ready_o), .m0_en_o(m0_en_o),
  .m0_we_o(m0_we_o), .m1_en_o(m1_en_o), .m1_we_o(m1_we_o)
);

// File: tb/pp_buffer_ctrl_bench.sv
`timescale 1ns/1ps
module pp_buffer_ctrl_bench;
  localparam int SW = 16, ROWS = 4, PAIRS = 3;
  localparam int DEPTH = ROWS * PAIRS, AW = $clog2(DEPTH), WW = 2 * SW;

  logic clk = 0, rst_n = 0, start_i = 0, rd_ready_i = 0, wr_valid_i = 0;
  logic [WW-1:0] wr_data_i = '0;
  logic pass_done_o, col_scan_o, rd_bank_o, proc_ce_o, rd_valid_o, wr_ready_o;
  logic [1:0] pass_idx_o;
  logic [WW-1:0] rd_data_o, m0_wdata_o, m1_wdata_o, m0_rdata_i, m1_rdata_i;
  logic m0_en_o, m0_we_o, m1_en_o, m1_we_o;
  logic [AW-1:0] m0_addr_o, m1_addr_o;

  pp_buffer_ctrl #(.SAMPLE_W(SW), .ROWS(ROWS), .PAIRS(PAIRS)) u_pp_buffer_ctrl (.*);

  always #2 clk = ~clk;

  logic [WW-1:0] bank0 [DEPTH];
  logic [WW-1:0] bank1 [DEPTH];
  always @(posedge clk) begin
    if (m0_en_o) begin
      if (m0_we_o) bank0[m0_addr_o] <= m0_wdata_o; else m0_rdata_i <= bank0[m0_addr_o];
    end
    if (m1_en_o) begin
      if (m1_we_o) bank1[m1_addr_o] <= m1_wdata_o; else m1_rdata_i <= bank1[m1_addr_o];
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;
  int cyc = 0, rd_n, wr_n, ra_n, wa_n, pd_n, pd_cyc, last_hs;
  int ce_viol, bank_viol, hold_viol;
  logic [WW-1:0] rd_log [64];
  int ra_log [64];
  int wa_log [64];
  logic stalled = 0;
  logic [WW-1:0] stall_word;
  logic [WW-1:0] snap [DEPTH];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Observation point, clear of both the driving negedge and the posedge.
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rd_valid_o && !proc_ce_o) ce_viol++;
    if (wr_ready_o && !proc_ce_o) ce_viol++;
    if (rd_bank_o ? (m1_we_o || (m0_en_o && !m0_we_o)) : (m0_we_o || (m1_en_o && !m1_we_o)))
      bank_viol++;
    if (rd_valid_o) begin
      if (stalled && rd_data_o != stall_word) hold_viol++;
      stalled = !rd_ready_i;
      stall_word = rd_data_o;
    end
    if (rd_valid_o && rd_ready_i) begin
      if (rd_n < 64) rd_log[rd_n] = rd_data_o;
      rd_n++; last_hs = cyc;
    end
    if (wr_valid_i && wr_ready_o) begin wr_n++; last_hs = cyc; end
    if (m0_en_o && m0_we_o && wa_n < 64) begin wa_log[wa_n] = int'(m0_addr_o); wa_n++; end
    if (m1_en_o && m1_we_o && wa_n < 64) begin wa_log[wa_n] = int'(m1_addr_o); wa_n++; end
    if (m0_en_o && !m0_we_o && ra_n < 64) begin ra_log[ra_n] = int'(m0_addr_o); ra_n++; end
    if (m1_en_o && !m1_we_o && ra_n < 64) begin ra_log[ra_n] = int'(m1_addr_o); ra_n++; end
    if (pass_done_o) begin pd_n++; pd_cyc = cyc; end
  end

  function automatic int scan_addr(input int k, input bit col);
    return col ? (k % ROWS) * PAIRS + (k / ROWS) : k;
  endfunction

  function automatic logic [WW-1:0] wpat(input int p, input int k);
    return 32'hA500_0000 | (p << 16) | (k * 7 + 3);
  endfunction

  task automatic test_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(!rd_valid_o && !wr_ready_o && !pass_done_o, "R1", "handshake outputs in reset", 0, 0);
    chk(!m0_en_o && !m1_en_o, "R1", "bank enables in reset", {m0_en_o, m1_en_o}, 0);
    chk(pass_idx_o == 0 && rd_bank_o == 0, "R1", "pass/bank in reset", {pass_idx_o, rd_bank_o}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    begin
      logic c0;
      c0 = proc_ce_o;
      @(negedge clk); #1;
      chk(proc_ce_o != c0, "R2", "enable toggles", proc_ce_o, !c0);
    end
    chk(!m0_en_o && !m1_en_o && !rd_valid_o, "R1", "idle after reset", {m0_en_o, m1_en_o}, 0);
  endtask

  // rmode/wmode: 0 = always willing, 1 = gapped pattern
  task automatic run_pass(input int p, input bit rmode, input bit wmode, input bit poke_start);
    bit col, src, dst_old;
    int t;
    col = (p == 1);
    src = rd_bank_o;
    dst_old = src;
    for (int a = 0; a < DEPTH; a++) snap[a] = src ? bank1[a] : bank0[a];
    rd_n = 0; wr_n = 0; ra_n = 0; wa_n = 0; pd_n = 0; pd_cyc = -1; last_hs = -1;
    ce_viol = 0; bank_viol = 0; hold_viol = 0; stalled = 0;
    chk(pass_idx_o == 2'(p) && col_scan_o == col, col ? "R5" : "R4", "pass index/scan mode",
        {pass_idx_o, col_scan_o}, {p[1:0], col});
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    t = 0;
    while (pd_n == 0 && t < 2000) begin
      rd_ready_i = rmode ? (t % 3 != 0) : 1'b1;
      wr_valid_i = wmode ? (t % 5 != 1) : 1'b1;
      wr_data_i  = wpat(p, wr_n);
      start_i    = poke_start && (t == 9);
      @(negedge clk);
      t++;
    end
    rd_ready_i = 0; wr_valid_i = 0; start_i = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(pd_n == 1, poke_start ? "R9" : "R8", "pass_done pulses", pd_n, 1);
    chk(pd_cyc == last_hs + 1, "R8", "pass_done timing", pd_cyc, last_hs + 1);
    chk(rd_bank_o != dst_old, "R8", "bank roles swapped", rd_bank_o, !dst_old);
    chk(pass_idx_o == 2'((p + 1) % 3), "R8", "pass index advanced", pass_idx_o, (p + 1) % 3);
    chk(rd_n == DEPTH, poke_start ? "R9" : "R7", "words delivered", rd_n, DEPTH);
    chk(wr_n == DEPTH && wa_n == DEPTH, "R3", "words written", wr_n, DEPTH);
    chk(ra_n == DEPTH, "R3", "reads issued", ra_n, DEPTH);
    chk(ce_viol == 0, "R2", "handshake outside enable", ce_viol, 0);
    chk(bank_viol == 0, "R3", "access to wrong bank", bank_viol, 0);
    chk(hold_viol == 0, "R7", "stalled word changed", hold_viol, 0);
    for (int k = 0; k < DEPTH; k++) begin
      int ea;
      logic [WW-1:0] dw;
      ea = scan_addr(k, col);
      if (k < ra_n) chk(ra_log[k] == ea, col ? "R5" : "R4", "read address", ra_log[k], ea);
      if (k < wa_n) chk(wa_log[k] == ea, col ? "R5" : "R4", "write address", wa_log[k], ea);
      if (k < rd_n) chk(rd_log[k] == snap[ea], "R6", "delivered word", rd_log[k], snap[ea]);
      dw = src ? bank0[ea] : bank1[ea];
      chk(dw == wpat(p, k), "R3", "destination contents", dw, wpat(p, k));
    end
  endtask

  task automatic test_packing();
    // Pass 0 source preloaded with samples s[n] = 0x100+n in row order.
    for (int k = 0; k < DEPTH; k++) begin
      chk(rd_log[k][SW-1:0] == 16'(16'h100 + 2 * k), "R6", "even sample in low half",
          rd_log[k][SW-1:0], 16'h100 + 2 * k);
      chk(rd_log[k][WW-1:SW] == 16'(16'h101 + 2 * k), "R6", "odd sample in high half",
          rd_log[k][WW-1:SW], 16'h101 + 2 * k);
    end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      bank0[a] = {16'(16'h101 + 2 * a), 16'(16'h100 + 2 * a)};
      bank1[a] = '0;
    end
    test_reset();
    run_pass(0, 1'b0, 1'b0, 1'b0);
    test_packing();
    run_pass(1, 1'b0, 1'b1, 1'b0);
    run_pass(2, 1'b1, 1'b1, 1'b1);
    chk(rd_bank_o == 1'b1 && pass_idx_o == 2'd0, "R8", "state after three passes",
        {pass_idx_o, rd_bank_o}, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule